// File: doc/BRIEF.md
# Analog-Shared Digital I/O Port

This block is a general-purpose digital port whose pins double as analog inputs. It has a bidirectional port (port A) with an output latch and a direction register, and an input-only port (port B). Input pins pass through two-stage synchronizers before software sees them. The synchronizers stay frozen until a bus access decodes to one of the two data registers. A pin that sits at a mid-level analog voltage is therefore not sampled by digital logic during normal analog use.

An external multiplexer mode takes over the low three pins of port A. When the mode is on, those pins are driven as outputs carrying a 3-bit multiplexer address, whatever their direction bits say. The address comes from outside the block. Reads of the port A data register return the synchronized pin value for input pins. For output pins they return the value being driven, so read-modify-write sequences keep their output values.

The bus side is a simple register port with four word addresses:

| Address | Register |
|---------|----------|
| 0 | Port A data |
| 1 | Port B data |
| 2 | Port A direction |
| 3 | Control |

Writes take effect at the accepting clock edge. Reads return data after a fixed pipeline delay.

Top module: `ioport_top`

## Requirements
- R1: After reset the port A direction register, output latch and control register are all zero. `padAOe` and `padAOut` are zero, and a read of port A returns the pin values.
- R2: A read accepted at clock edge N raises `busRValid` for exactly the one cycle between edges N+1 and N+2, with `busRData` valid in that cycle. A write, or a cycle with `busSel` low, produces no `busRValid` two edges later.
- R3: The synchronizers sample the pins only at the edge that accepts an access to a data register. A change on the pins after that edge does not alter that read's result.
- R4: A port A data read returns the synchronized pin value for every bit whose direction bit (register 2) is 0 and which is not forced by the multiplexer mode.
- R5: A port A data read returns the output latch bit for every bit whose direction bit is 1 and which is not forced by the multiplexer mode.
- R6: A write to address 0 updates the output latch whatever the direction bits are.
- R7: `padAOe` equals the direction register, and `padAOut` equals the output latch, on every bit not forced by the multiplexer mode.
- R8: While control bit 0 (multiplexer mode) is 1, bits 2:0 of `padAOe` are 1 and bits 2:0 of `padAOut` equal `muxAddr`, regardless of direction bits. Bits 2:0 of a port A read return `muxAddr`. Clearing the bit returns those pins to direction control.
- R9: Port B is input-only. A read of address 1 returns the synchronized `padBIn`, and writes to address 1 change nothing.
- R10: The direction register reads back as written. The control register reads back bit 0 as written, with all other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request, accepted at the next rising edge |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 2 | Register address (0 port A data, 1 port B data, 2 direction, 3 control) |
| busWData | input | DATA_W | Write data |
| busRData | output | DATA_W | Read data, zero when no result is due |
| busRValid | output | 1 | Read result present |
| padAIn | input | PORT_A_W | Port A pin input values |
| padBIn | input | PORT_B_W | Port B pin input values |
| muxAddr | input | MUX_W | External multiplexer address to drive in mux mode |
| padAOut | output | PORT_A_W | Port A output values |
| padAOe | output | PORT_A_W | Port A output enables |

## Verification
Register writes act at the accepting edge, so the pin outputs `padAOe` and `padAOut` are checked on the falling edge right after that edge. Read results travel through the two synchronizer stages. The bench therefore checks that `busRValid` is low half a cycle after acceptance, high and carrying the data one full edge later, and low again after the following edge. For the sampling-instant check, the pins are changed on the falling edge just after acceptance. The read must still return the earlier value, and the next read must return the new one.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  typedef enum logic [1:0] {
    REG_DATA_A = 2'd0,
    REG_DATA_B = 2'd1,
    REG_DIR_A  = 2'd2,
    REG_CTRL   = 2'd3
  } regSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    wrLatch;   // load port A output latch
    logic    wrDir;     // load direction register
    logic    wrCtrl;    // load control register
    logic    capA;      // synchronizer stage 1 capture, port A
    logic    capB;      // synchronizer stage 1 capture, port B
    logic    shiftA;    // synchronizer stage 2 capture, port A
    logic    shiftB;    // synchronizer stage 2 capture, port B
    logic    rdValid;   // read result due this cycle
    regSel_e rdSel;     // register the result comes from
  } portStrobes_t;

endpackage

// File: rtl/ioport_ctrl.sv
module ioport_ctrl
  import ioport_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         busSel,
  input  logic         busWrite,
  input  logic [1:0]   busAddr,
  output portStrobes_t strobes
);

  regSel_e addrSel;
  logic    acceptRd;
  logic    acceptWr;

  logic    pend1Valid;
  regSel_e pend1Sel;
  logic    pend2Valid;
  regSel_e pend2Sel;

  assign addrSel  = regSel_e'(busAddr);
  assign acceptRd = busSel && !busWrite;
  assign acceptWr = busSel && busWrite;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend1Valid <= 1'b0;
      pend1Sel   <= REG_DATA_A;
      pend2Valid <= 1'b0;
      pend2Sel   <= REG_DATA_A;
    end else begin
      pend1Valid <= acceptRd;
      pend1Sel   <= addrSel;
      pend2Valid <= pend1Valid;
      pend2Sel   <= pend1Sel;
    end
  end

  always_comb begin
    strobes.wrLatch = acceptWr && (addrSel == REG_DATA_A);
    strobes.wrDir   = acceptWr && (addrSel == REG_DIR_A);
    strobes.wrCtrl  = acceptWr && (addrSel == REG_CTRL);
    // any access that decodes to a data register wakes its synchronizer
    strobes.capA    = busSel && (addrSel == REG_DATA_A);
    strobes.capB    = busSel && (addrSel == REG_DATA_B);
    strobes.shiftA  = pend1Valid && (pend1Sel == REG_DATA_A);
    strobes.shiftB  = pend1Valid && (pend1Sel == REG_DATA_B);
    strobes.rdValid = pend2Valid;
    strobes.rdSel   = pend2Sel;
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    acceptRd |-> ##2 strobes.rdValid); // R2

  AST_SHIFT_AFTER_CAP_A: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftA |-> $past(strobes.capA)); // R3

  AST_SHIFT_AFTER_CAP_B: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shiftB |-> $past(strobes.capB)); // R3

endmodule

// File: rtl/ioport_dp.sv
module ioport_dp
  import ioport_pkg::*;
#(
  parameter int PORT_A_W = 8,
  parameter int PORT_B_W = 8,
  parameter int MUX_W    = 3,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobes_t        strobes,
  input  logic [DATA_W-1:0]   busWData,
  input  logic [PORT_A_W-1:0] padAIn,
  input  logic [PORT_B_W-1:0] padBIn,
  input  logic [MUX_W-1:0]    muxAddr,
  output logic [PORT_A_W-1:0] padAOut,
  output logic [PORT_A_W-1:0] padAOe,
  output logic [DATA_W-1:0]   rdData
);

  logic [PORT_A_W-1:0] latchA;
  logic [PORT_A_W-1:0] dirA;
  logic                modeReg;
  logic [PORT_A_W-1:0] stage1A;
  logic [PORT_A_W-1:0] stage2A;
  logic [PORT_B_W-1:0] stage1B;
  logic [PORT_B_W-1:0] stage2B;

  logic [PORT_A_W-1:0] forceOut;
  logic [PORT_A_W-1:0] drvVal;
  logic [PORT_A_W-1:0] readA;

  // register file
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchA  <= '0;
      dirA    <= '0;
      modeReg <= 1'b0;
    end else begin
      if (strobes.wrLatch) latchA  <= busWData[PORT_A_W-1:0];
      if (strobes.wrDir)   dirA    <= busWData[PORT_A_W-1:0];
      if (strobes.wrCtrl)  modeReg <= busWData[0];
    end
  end

  // gated two-stage synchronizers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1A <= '0;
      stage2A <= '0;
      stage1B <= '0;
      stage2B <= '0;
    end else begin
      if (strobes.capA)   stage1A <= padAIn;
      if (strobes.shiftA) stage2A <= stage1A;
      if (strobes.capB)   stage1B <= padBIn;
      if (strobes.shiftB) stage2B <= stage1B;
    end
  end

  // per-pin drive selection
  for (genvar i = 0; i < PORT_A_W; i++) begin : g_pin
    if (i < MUX_W) begin : g_muxPin
      assign forceOut[i] = modeReg;
      assign drvVal[i]   = modeReg ? muxAddr[i] : latchA[i];
    end else begin : g_plainPin
      assign forceOut[i] = 1'b0;
      assign drvVal[i]   = latchA[i];
    end
  end

  assign padAOe  = dirA | forceOut;
  assign padAOut = drvVal;
  assign readA   = (padAOe & drvVal) | (~padAOe & stage2A);

  always_comb begin
    rdData = '0;
    if (strobes.rdValid) begin
      case (strobes.rdSel)
        REG_DATA_A: rdData[PORT_A_W-1:0] = readA;
        REG_DATA_B: rdData[PORT_B_W-1:0] = stage2B;
        REG_DIR_A:  rdData[PORT_A_W-1:0] = dirA;
        REG_CTRL:   rdData[0]            = modeReg;
        default:    rdData               = '0;
      endcase
    end
  end

  AST_SYNC_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capA |=> $stable(stage1A)); // R3

  AST_SYNC_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capB |=> $stable(stage1B)); // R9

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrLatch |=> $stable(latchA)); // R6

  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.wrDir |=> $stable(dirA)); // R10

endmodule

// File: rtl/ioport_top.sv
module ioport_top
  import ioport_pkg::*;
#(
  parameter int PORT_A_W = 8,
  parameter int PORT_B_W = 8,
  parameter int MUX_W    = 3,
  localparam int DATA_W  = (PORT_A_W > PORT_B_W) ? PORT_A_W : PORT_B_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWrite,
  input  logic [1:0]          busAddr,
  input  logic [DATA_W-1:0]   busWData,
  output logic [DATA_W-1:0]   busRData,
  output logic                busRValid,
  input  logic [PORT_A_W-1:0] padAIn,
  input  logic [PORT_B_W-1:0] padBIn,
  input  logic [MUX_W-1:0]    muxAddr,
  output logic [PORT_A_W-1:0] padAOut,
  output logic [PORT_A_W-1:0] padAOe
);

  portStrobes_t strobes;

  ioport_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes)
  );

  ioport_dp #(
    .PORT_A_W (PORT_A_W),
    .PORT_B_W (PORT_B_W),
    .MUX_W    (MUX_W),
    .DATA_W   (DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWData (busWData),
    .padAIn   (padAIn),
    .padBIn   (padBIn),
    .muxAddr  (muxAddr),
    .padAOut  (padAOut),
    .padAOe   (padAOe),
    .rdData   (busRData)
  );

  assign busRValid = strobes.rdValid;

  AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    (!busSel || busWrite) |-> ##2 !busRValid); // R2

  AST_RDATA_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRValid |-> (busRData == '0)); // R2

endmodule

// File: tb/ioport_top_tb.sv
module ioport_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWrite = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWData = 8'd0;
  logic [7:0] busRData;
  logic       busRValid;
  logic [7:0] padAIn = 8'd0;
  logic [7:0] padBIn = 8'd0;
  logic [2:0] muxAddr = 3'd0;
  logic [7:0] padAOut;
  logic [7:0] padAOe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioport_top u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWData  (busWData),
    .busRData  (busRData),
    .busRValid (busRValid),
    .padAIn    (padAIn),
    .padBIn    (padBIn),
    .muxAddr   (muxAddr),
    .padAOut   (padAOut),
    .padAOe    (padAOe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWData = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(busRValid == 1'b0, "R2 write gives no result", 32'(busRValid), 0);
  endtask

  // read; optionally change port A pins right after the accepting edge
  task automatic doRead(input logic [1:0] a, input bit change, input logic [7:0] newPins,
                        output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0;
    if (change) padAIn = newPins;
    chk(busRValid == 1'b0, "R2 no result one edge early", 32'(busRValid), 0);
    @(posedge clk);
    @(negedge clk);
    chk(busRValid == 1'b1, "R2 result due", 32'(busRValid), 1);
    d = busRData;
    @(posedge clk);
    @(negedge clk);
    chk(busRValid == 1'b0, "R2 result lasts one cycle", 32'(busRValid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    padAIn = 8'hA5;
    padBIn = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(padAOe == 8'h00, "R1 oe after reset", 32'(padAOe), 0);
    chk(padAOut == 8'h00, "R1 out after reset", 32'(padAOut), 0);
    doRead(2'd2, 1'b0, 8'h0, rd);
    chk(rd == 8'h00, "R1 dir reset", 32'(rd), 0);
    doRead(2'd3, 1'b0, 8'h0, rd);
    chk(rd == 8'h00, "R1 ctrl reset", 32'(rd), 0);
    doRead(2'd0, 1'b0, 8'h0, rd);
    chk(rd == 8'hA5, "R1 port A reads pins", 32'(rd), 32'hA5);

    // R10 register readback
    doWrite(2'd2, 8'h3C);
    doRead(2'd2, 1'b0, 8'h0, rd);
    chk(rd == 8'h3C, "R10 dir readback", 32'(rd), 32'h3C);
    doWrite(2'd3, 8'hFF);
    doRead(2'd3, 1'b0, 8'h0, rd);
    chk(rd == 8'h01, "R10 ctrl readback", 32'(rd), 1);
    doWrite(2'd3, 8'h00);
    doRead(2'd3, 1'b0, 8'h0, rd);
    chk(rd == 8'h00, "R10 ctrl cleared", 32'(rd), 0);

    // R3 sampling instant
    doWrite(2'd2, 8'h00);
    padAIn = 8'h33;
    doRead(2'd0, 1'b1, 8'hCC, rd);
    chk(rd == 8'h33, "R3 sample taken at accepting edge", 32'(rd), 32'h33);
    doRead(2'd0, 1'b0, 8'h0, rd);
    chk(rd == 8'hCC, "R3 next access resamples", 32'(rd), 32'hCC);

    // R6 latch written while all pins are inputs, then revealed
    doWrite(2'd0, 8'h96);
    chk(padAOut == 8'h96, "R6 latch loaded with dir zero", 32'(padAOut), 32'h96);
    doWrite(2'd2, 8'hFF);
    doRead(2'd0, 1'b0, 8'h0, rd);
    chk(rd == 8'h96, "R6 latch read after turning outputs on", 32'(rd), 32'h96);

    // R4 R5 R7 sweep over every direction pattern
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dir, lat, pins, exp;
      dir  = 8'(d);
      lat  = 8'(d) ^ 8'h5A;
      pins = 8'(d * 37 + 11);
      doWrite(2'd0, lat);
      doWrite(2'd2, dir);
      padAIn = pins;
      chk(padAOe == dir, "R7 oe follows dir", 32'(padAOe), 32'(dir));
      chk(padAOut == lat, "R7 out follows latch", 32'(padAOut), 32'(lat));
      doRead(2'd0, 1'b0, 8'h0, rd);
      exp = (dir & lat) | (~dir & pins);
      chk(rd == exp, "R4 R5 mixed readback", 32'(rd), 32'(exp));
    end

    // R8 multiplexer mode sweep
    doWrite(2'd3, 8'h01);
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dir, lat, pins, exp, expOe, expOut;
      logic [2:0] m;
      dir  = 8'(d);
      lat  = 8'(d * 5);
      pins = ~8'(d);
      m    = 3'(d) ^ 3'(d >> 3);
      muxAddr = m;
      doWrite(2'd0, lat);
      doWrite(2'd2, dir);
      padAIn = pins;
      expOe  = dir | 8'h07;
      expOut = {lat[7:3], m};
      chk(padAOe == expOe, "R8 low pins forced out", 32'(padAOe), 32'(expOe));
      chk(padAOut == expOut, "R8 low pins drive mux address", 32'(padAOut), 32'(expOut));
      doRead(2'd0, 1'b0, 8'h0, rd);
      exp = {(dir[7:3] & lat[7:3]) | (~dir[7:3] & pins[7:3]), m};
      chk(rd == exp, "R8 readback in mux mode", 32'(rd), 32'(exp));
    end
    doWrite(2'd2, 8'h00);
    doWrite(2'd0, 8'h00);
    doWrite(2'd3, 8'h00);
    chk(padAOe == 8'h00, "R8 release returns to dir control", 32'(padAOe), 0);
    chk(padAOut == 8'h00, "R8 release returns latch drive", 32'(padAOut), 0);

    // R9 input-only port
    padBIn = 8'h12;
    doWrite(2'd1, 8'hFF);
    chk(padAOut == 8'h00, "R9 port B write leaves port A latch", 32'(padAOut), 0);
    doRead(2'd1, 1'b0, 8'h0, rd);
    chk(rd == 8'h12, "R9 port B write ignored", 32'(rd), 32'h12);
    for (int p = 0; p < 256; p++) begin
      padBIn = 8'(p);
      doRead(2'd1, 1'b0, 8'h0, rd);
      chk(rd == 8'(p), "R9 port B reads pins", 32'(rd), 32'(p));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule